// File: doc/BRIEF.md
# Bias-Preloaded Sequenced Multiply-Accumulate Unit

This block computes the weighted sum of one neuron in signed fixed point. It forms one product per clock from a small internal store of input features and weights. A single start pulse runs a fixed sequence: one set-up cycle, a first-multiply cycle, a run of multiply-accumulate cycles, one final-accumulate cycle and one hand-off cycle, after which the unit is idle again. The bias is written into the accumulator during the set-up cycle. The first product therefore lands directly on top of the bias, and no separate bias register, bias multiplexer or extra cycle is needed.

At the end of a run the unit presents two results. One is the full-width sum, with guard bits against overflow and twice the fraction bits of the operands. The other is the sum narrowed back to the operand format, with saturation. A precision-select input, captured at the start of the run, decides which of the two is passed on to the activation stage on `mac_out`. A one-cycle done pulse marks the hand-off.

Top module: `neuron_mac_seq`

## Requirements
- R1: While reset is held and after it is released, `busy` and `done` are 0 and `result_full`, `result_q` and `mac_out` are 0.
- R2: A `start` sampled high while idle begins a run. `busy` is high from the next cycle through the hand-off cycle. `done` is high for exactly one cycle, on the (NUM_IN+2)th rising edge after the edge that sampled `start`, and `done` implies `busy`.
- R3: A `start` pulse sampled while `busy` is high is ignored. It produces no extra result, and it does not change the timing, the values or the precision selection of the run in progress.
- R4: `result_full` is ACC_W = 2*DATA_W + clog2(NUM_IN) bits wide, two's complement, with 2*FRAC_W fraction bits. Its value is (bias * 2^FRAC_W) + sum over i of x[i]*w[i].
- R5: `bias` is a signed DATA_W-bit value with FRAC_W fraction bits. It is sign-extended before alignment, so negative biases subtract. It is sampled on the rising edge that ends the set-up cycle.
- R6: When the value floor(result_full / 2^FRAC_W) fits in DATA_W signed bits, `result_q` equals that value (the low FRAC_W bits are dropped).
- R7: When floor(result_full / 2^FRAC_W) exceeds 2^(DATA_W-1)-1, `result_q` is 2^(DATA_W-1)-1 (0x7F by default). When it is below -2^(DATA_W-1), `result_q` is -2^(DATA_W-1) (0x80 by default).
- R8: `prec_sel` is sampled together with `bias`. A value of 0 makes `mac_out` equal `result_full`. A value of 1 makes `mac_out` equal `result_q` sign-extended to ACC_W bits.
- R9: On a rising edge with `wr_en` high and the unit idle, `wr_data` is written to entry `wr_addr` of the weight store when `wr_is_weight`=1, or of the input store when `wr_is_weight`=0. Writes while `busy` is high are ignored.
- R10: `result_full`, `result_q` and `mac_out` change only on the edge that raises `done`. They hold their values between runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Store write strobe |
| wr_is_weight | input | 1 | 1 selects the weight store, 0 selects the input store |
| wr_addr | input | clog2(NUM_IN) | Store entry index |
| wr_data | input | DATA_W | Signed value to write |
| bias | input | DATA_W | Signed bias in the operand format |
| start | input | 1 | Compute-init pulse |
| prec_sel | input | 1 | 1 selects the narrowed sum for `mac_out`, 0 selects the full sum |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle hand-off pulse |
| result_full | output | ACC_W | Unquantized sum |
| result_q | output | DATA_W | Narrowed, saturated sum |
| mac_out | output | ACC_W | Selected sum for the activation stage |

## Verification
The checker watches the run framing on every cycle: a single-cycle `done` that always falls inside `busy`, the fixed start-to-done distance that a late restart would break, output stability between hand-offs, and the agreement between the narrowed sum, the full sum and the selected output, including the saturation bounds. Only the bench scenarios can show that the full sum actually equals the bias plus the dot product of what was written. The same holds for negative-bias alignment and for precision selection taken from the start of the run. It also holds for a store write during a run being discarded, which shows up only in the result of the next run.

// File: rtl/neuron_mac_pkg.sv
package neuron_mac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_FIRST,
    ST_ACCUM,
    ST_LAST,
    ST_HANDOFF
  } mac_state_t;

endpackage

// File: rtl/mac_operand_rf.sv
module mac_operand_rf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int AW     = 3
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic                     wr_is_weight,
  input  logic [AW-1:0]            wr_addr,
  input  logic signed [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]            rd_addr,
  output logic signed [DATA_W-1:0] rd_x,
  output logic signed [DATA_W-1:0] rd_w
);

  logic signed [DATA_W-1:0] x_mem [DEPTH];
  logic signed [DATA_W-1:0] w_mem [DEPTH];

  logic addr_ok;
  assign addr_ok = (32'(wr_addr) < DEPTH);

  always_ff @(posedge clk) begin
    if (wr_en && addr_ok && !wr_is_weight) x_mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (wr_en && addr_ok && wr_is_weight) w_mem[wr_addr] <= wr_data;
  end

  assign rd_x = x_mem[rd_addr];
  assign rd_w = w_mem[rd_addr];

endmodule

// File: rtl/mac_seq_ctrl.sv
module mac_seq_ctrl
  import neuron_mac_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int AW     = 3,
  parameter int CW     = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic [AW-1:0] rd_ptr,
  output logic          bias_load,
  output logic          mul_en,
  output logic          acc_en,
  output logic          out_load,
  output logic          busy
);

  mac_state_t    state;
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      remain <= '0;
      rd_ptr <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) state <= ST_SETUP;
        end
        ST_SETUP: begin
          rd_ptr <= '0;
          state  <= ST_FIRST;
        end
        ST_FIRST: begin
          remain <= CW'(NUM_IN - 1);
          rd_ptr <= AW'(1);
          state  <= (NUM_IN > 1) ? ST_ACCUM : ST_LAST;
        end
        ST_ACCUM: begin
          remain <= remain - CW'(1);
          rd_ptr <= rd_ptr + AW'(1);
          if (remain == CW'(1)) state <= ST_LAST;
        end
        ST_LAST:    state <= ST_HANDOFF;
        ST_HANDOFF: state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assign bias_load = (state == ST_SETUP);
  assign mul_en    = (state == ST_FIRST) || (state == ST_ACCUM);
  assign acc_en    = mul_en || (state == ST_LAST);
  assign out_load  = (state == ST_LAST);
  assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/mac_accum_path.sv
module mac_accum_path #(
  parameter int DATA_W = 8,
  parameter int FRAC_W = 6,
  parameter int ACC_W  = 19
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bias_load,
  input  logic                     mul_en,
  input  logic                     acc_en,
  input  logic signed [DATA_W-1:0] bias,
  input  logic signed [DATA_W-1:0] op_x,
  input  logic signed [DATA_W-1:0] op_w,
  output logic signed [ACC_W-1:0]  sum_next
);

  localparam int PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  bias_wide;
  logic signed [ACC_W-1:0]  bias_aligned;

  // Bias is in the operand format; move it onto the product fraction grid.
  assign bias_wide    = ACC_W'(bias);
  assign bias_aligned = bias_wide <<< FRAC_W;
  assign sum_next     = acc + ACC_W'(prod);

  always_ff @(posedge clk) begin
    if (rst) begin
      prod <= '0;
      acc  <= '0;
    end else if (bias_load) begin
      prod <= '0;
      acc  <= bias_aligned;
    end else begin
      if (mul_en) prod <= op_x * op_w;
      if (acc_en) acc  <= sum_next;
    end
  end

endmodule

// File: rtl/mac_out_stage.sv
module mac_out_stage #(
  parameter int DATA_W = 8,
  parameter int FRAC_W = 6,
  parameter int ACC_W  = 19
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sel_load,
  input  logic                     prec_sel,
  input  logic                     out_load,
  input  logic signed [ACC_W-1:0]  sum_in,
  output logic signed [ACC_W-1:0]  result_full,
  output logic signed [DATA_W-1:0] result_q,
  output logic signed [ACC_W-1:0]  mac_out,
  output logic                     done
);

  localparam logic signed [ACC_W-1:0] Q_MAX = ACC_W'(2 ** (DATA_W - 1) - 1);
  localparam logic signed [ACC_W-1:0] Q_MIN = ACC_W'(-(2 ** (DATA_W - 1)));

  logic                     narrow_sel;
  logic signed [ACC_W-1:0]  shifted;
  logic signed [DATA_W-1:0] q_sat;

  assign shifted = sum_in >>> FRAC_W;

  always_comb begin
    if (shifted > Q_MAX)      q_sat = Q_MAX[DATA_W-1:0];
    else if (shifted < Q_MIN) q_sat = Q_MIN[DATA_W-1:0];
    else                      q_sat = shifted[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      narrow_sel  <= 1'b0;
      result_full <= '0;
      result_q    <= '0;
      mac_out     <= '0;
      done        <= 1'b0;
    end else begin
      done <= out_load;
      if (sel_load) narrow_sel <= prec_sel;
      if (out_load) begin
        result_full <= sum_in;
        result_q    <= q_sat;
        mac_out     <= narrow_sel ? ACC_W'(q_sat) : sum_in;
      end
    end
  end

endmodule

// File: rtl/neuron_mac_seq.sv
module neuron_mac_seq #(
  parameter int   NUM_IN = 8,
  parameter int   DATA_W = 8,
  parameter int   FRAC_W = 6,
  localparam int  AW     = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int  ACC_W  = 2 * DATA_W + AW
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     wr_is_weight,
  input  logic [AW-1:0]            wr_addr,
  input  logic signed [DATA_W-1:0] wr_data,
  input  logic signed [DATA_W-1:0] bias,
  input  logic                     start,
  input  logic                     prec_sel,
  output logic                     busy,
  output logic                     done,
  output logic signed [ACC_W-1:0]  result_full,
  output logic signed [DATA_W-1:0] result_q,
  output logic signed [ACC_W-1:0]  mac_out
);

  localparam int CW = $clog2(NUM_IN + 1);

  logic [AW-1:0]            rd_ptr;
  logic                     bias_load;
  logic                     mul_en;
  logic                     acc_en;
  logic                     out_load;
  logic signed [DATA_W-1:0] op_x;
  logic signed [DATA_W-1:0] op_w;
  logic signed [ACC_W-1:0]  sum_next;
  logic                     rf_we;

  assign rf_we = wr_en && !busy;

  mac_operand_rf #(.DATA_W(DATA_W), .DEPTH(NUM_IN), .AW(AW)) u_rf (
    .clk          (clk),
    .wr_en        (rf_we),
    .wr_is_weight (wr_is_weight),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rd_addr      (rd_ptr),
    .rd_x         (op_x),
    .rd_w         (op_w)
  );

  mac_seq_ctrl #(.NUM_IN(NUM_IN), .AW(AW), .CW(CW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .rd_ptr    (rd_ptr),
    .bias_load (bias_load),
    .mul_en    (mul_en),
    .acc_en    (acc_en),
    .out_load  (out_load),
    .busy      (busy)
  );

  mac_accum_path #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_path (
    .clk       (clk),
    .rst       (rst),
    .bias_load (bias_load),
    .mul_en    (mul_en),
    .acc_en    (acc_en),
    .bias      (bias),
    .op_x      (op_x),
    .op_w      (op_w),
    .sum_next  (sum_next)
  );

  mac_out_stage #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .sel_load    (bias_load),
    .prec_sel    (prec_sel),
    .out_load    (out_load),
    .sum_in      (sum_next),
    .result_full (result_full),
    .result_q    (result_q),
    .mac_out     (mac_out),
    .done        (done)
  );

endmodule

// File: rtl/mac_seq_checker.sv
module mac_seq_checker #(
  parameter int NUM_IN = 8,
  parameter int DATA_W = 8,
  parameter int FRAC_W = 6,
  parameter int ACC_W  = 19
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     start,
  input logic                     busy,
  input logic                     done,
  input logic signed [ACC_W-1:0]  result_full,
  input logic signed [DATA_W-1:0] result_q,
  input logic signed [ACC_W-1:0]  mac_out
);

  localparam int LAT = NUM_IN + 3;
  localparam logic signed [ACC_W-1:0] Q_MAX  = ACC_W'(2 ** (DATA_W - 1) - 1);
  localparam logic signed [ACC_W-1:0] Q_MIN  = ACC_W'(-(2 ** (DATA_W - 1)));
  localparam logic signed [ACC_W-1:0] Q_STEP = ACC_W'(2 ** FRAC_W);

  logic [15:0]             run_cnt;
  logic signed [ACC_W-1:0] full_shift;
  logic signed [ACC_W-1:0] q_wide;
  logic signed [ACC_W-1:0] resid;
  logic                    fits;

  assign full_shift = result_full >>> FRAC_W;
  assign q_wide     = ACC_W'(result_q);
  assign resid      = result_full - (q_wide <<< FRAC_W);
  assign fits       = (full_shift <= Q_MAX) && (full_shift >= Q_MIN);

  always_ff @(posedge clk) begin
    if (rst)                 run_cnt <= '0;
    else if (!busy && start) run_cnt <= 16'd1;
    else if (busy)           run_cnt <= run_cnt + 16'd1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !done);

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_in_run_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  // A restart accepted mid-run would stretch this distance (R3).
  assert_done_latency_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_cnt == 16'(LAT)));

  assert_quant_floor_R6: assert property (@(posedge clk) disable iff (rst)
    (done && fits) |-> ((resid >= 0) && (resid < Q_STEP)));

  assert_sat_high_R7: assert property (@(posedge clk) disable iff (rst)
    (done && (full_shift > Q_MAX)) |-> (q_wide == Q_MAX));

  assert_sat_low_R7: assert property (@(posedge clk) disable iff (rst)
    (done && (full_shift < Q_MIN)) |-> (q_wide == Q_MIN));

  assert_sel_choice_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> ((mac_out == result_full) || (mac_out == q_wide)));

  assert_outputs_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(result_full) && $stable(result_q) && $stable(mac_out)));

endmodule

bind neuron_mac_seq mac_seq_checker #(
  .NUM_IN (NUM_IN),
  .DATA_W (DATA_W),
  .FRAC_W (FRAC_W),
  .ACC_W  (ACC_W)
) u_checker (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .result_full (result_full),
  .result_q    (result_q),
  .mac_out     (mac_out)
);

// File: tb/tb_neuron_mac_seq.sv
module tb_neuron_mac_seq;

  localparam int NUM_IN = 8;
  localparam int DATA_W = 8;
  localparam int FRAC_W = 6;
  localparam int AW     = 3;
  localparam int ACC_W  = 2 * DATA_W + AW;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic                     wr_en = 1'b0;
  logic                     wr_is_weight = 1'b0;
  logic [AW-1:0]            wr_addr = '0;
  logic signed [DATA_W-1:0] wr_data = '0;
  logic signed [DATA_W-1:0] bias = '0;
  logic                     start = 1'b0;
  logic                     prec_sel = 1'b0;
  logic                     busy;
  logic                     done;
  logic signed [ACC_W-1:0]  result_full;
  logic signed [DATA_W-1:0] result_q;
  logic signed [ACC_W-1:0]  mac_out;

  always #5 clk = ~clk;

  neuron_mac_seq #(.NUM_IN(NUM_IN), .DATA_W(DATA_W), .FRAC_W(FRAC_W)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_is_weight(wr_is_weight),
    .wr_addr(wr_addr), .wr_data(wr_data), .bias(bias), .start(start),
    .prec_sel(prec_sel), .busy(busy), .done(done), .result_full(result_full),
    .result_q(result_q), .mac_out(mac_out)
  );

  typedef struct {
    logic [ACC_W-1:0]  full;
    logic [DATA_W-1:0] q;
    logic [ACC_W-1:0]  outv;
    int                cyc;
    string             tag;
  } exp_t;

  exp_t sb_q[$];
  int   mx[NUM_IN];
  int   mw[NUM_IN];
  int   checks = 0;
  int   failures = 0;
  int   cyc = 0;
  bit   finished = 0;
  logic [ACC_W-1:0]  last_full;
  logic [DATA_W-1:0] last_q;
  logic [ACC_W-1:0]  last_out;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Monitor: pops one expected item per done pulse.
  always @(negedge clk) begin
    if (!rst && done && !finished) begin
      if (sb_q.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R3 unexpected done actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check("R4", {e.tag, " full"}, longint'(result_full), longint'($signed(e.full)));
        check("R6", {e.tag, " narrow"}, longint'(result_q), longint'($signed(e.q)));
        check("R8", {e.tag, " mac_out"}, longint'(mac_out), longint'($signed(e.outv)));
        check("R2", {e.tag, " latency"}, longint'(cyc), longint'(e.cyc));
        last_full = result_full;
        last_q    = result_q;
        last_out  = mac_out;
      end
    end
  end

  task automatic wr(input bit is_w, input int a, input int v, input bit track);
    @(negedge clk);
    wr_en = 1'b1; wr_is_weight = is_w; wr_addr = AW'(a); wr_data = DATA_W'(v);
    @(negedge clk);
    wr_en = 1'b0;
    if (track) begin
      if (is_w) mw[a] = v; else mx[a] = v;
    end
  endtask

  task automatic launch(input int b, input bit sel, input string tag);
    exp_t   e;
    longint full;
    longint sh;
    longint qv;
    full = longint'(b) * (2 ** FRAC_W);
    for (int i = 0; i < NUM_IN; i++) full += longint'(mx[i]) * longint'(mw[i]);
    sh = full >>> FRAC_W;
    if (sh > 127) qv = 127;
    else if (sh < -128) qv = -128;
    else qv = sh;
    e.full = ACC_W'(full);
    e.q    = DATA_W'(qv);
    e.outv = sel ? ACC_W'(qv) : ACC_W'(full);
    e.tag  = tag;
    @(negedge clk);
    e.cyc = cyc + NUM_IN + 3;
    sb_q.push_back(e);
    start = 1'b1; bias = DATA_W'(b); prec_sel = sel;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic settle();
    repeat (NUM_IN + 6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", longint'(busy), 0);
    check("R1", "done in reset", longint'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "busy after reset", longint'(busy), 0);
    check("R1", "full after reset", longint'(result_full), 0);
    check("R1", "narrow after reset", longint'(result_q), 0);
    check("R1", "mac_out after reset", longint'(mac_out), 0);

    // Pattern A (R9 loading path)
    for (int i = 0; i < NUM_IN; i++) begin
      wr(1'b0, i, i * 5 - 17, 1'b1);
      wr(1'b1, i, 23 - i * 7, 1'b1);
    end
    launch(10, 1'b0, "R4 patA full");   settle();
    launch(10, 1'b1, "R8 patA narrow"); settle();
    launch(-100, 1'b0, "R5 negbias");   settle();
    launch(-100, 1'b1, "R5 negbias q"); settle();

    // Positive saturation (R7)
    for (int i = 0; i < NUM_IN; i++) begin
      wr(1'b0, i, 127, 1'b1);
      wr(1'b1, i, 127, 1'b1);
    end
    launch(127, 1'b1, "R7 sat high"); settle();
    // Negative saturation (R7)
    for (int i = 0; i < NUM_IN; i++) wr(1'b1, i, -128, 1'b1);
    launch(-128, 1'b1, "R7 sat low"); settle();

    // Pattern B, then a restart and a write during the run (R3, R9)
    for (int i = 0; i < NUM_IN; i++) begin
      wr(1'b0, i, (i * 37) % 101 - 50, 1'b1);
      wr(1'b1, i, (i * 53) % 89 - 44, 1'b1);
    end
    launch(33, 1'b0, "R3 patB");
    @(negedge clk);
    start = 1'b1; prec_sel = 1'b1; bias = 8'sd90;
    @(negedge clk);
    start = 1'b0;
    wr(1'b0, 0, 99, 1'b0);
    settle();
    repeat (6) @(negedge clk);
    check("R3", "no extra result", longint'(sb_q.size()), 0);
    check("R10", "full held", longint'(result_full), longint'($signed(last_full)));
    check("R10", "narrow held", longint'(result_q), longint'($signed(last_q)));
    check("R10", "mac_out held", longint'(mac_out), longint'($signed(last_out)));
    launch(33, 1'b0, "R9 write ignored"); settle();

    check("R2", "all results seen", longint'(sb_q.size()), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL R2 watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule